// File: doc/BRIEF.md
# Reference clock mode controller

This block is the mode controller of a synchronous-equipment timing unit. It decides whether the output clock runs free on the local oscillator, is hunting for a reference, is locking to one, or is coasting on stored history. It does not filter anything or steer an oscillator. It takes in the operator's requested mode, per-reference health flags and progress strobes from the loop. It returns the state, the reference that is in use and a compact status code for the rest of the timing subsystem.

The requested mode comes either from a 3-bit pin code or from a 4-bit register code. A source-select bit picks which one. A new request is acted on only when the code changes. Loss of the reference in use, an automatic fallback to the best-priority reference and a revertive return to the chosen reference are handled without any request. A history tracker counts cycles spent in tracking. Holdover from free-run is allowed only after that count is reached, and a clear pulse discards the history.

Top module: `refclk_mode_ctrl`

## Requirements
- R1: After reset the block is in free-run: `mode_o`=0, `pll_status`=9, `status_byte`=0x09, `freerun_ind`=1. At most one of `holdover_ind`, `freerun_ind` and `unlock_ind` is high at any time. `mode_o` encodes 0 free-run, 1 reference switching, 2 locking, 3 holdover.
- R2: The pin codes are 000 free-run, 001 ref1, 010 ref2, 011 holdover, 100 ref3, 101 ref4, 110 ref5, 111 ref6. A request acts only on the clock edge after its code changes.
- R3: When `use_reg`=1, `pin_mode` is ignored and `reg_mode` is used. Register codes with bit 3 clear map like the pin codes. Register codes with bit 3 set leave the state and the reference unchanged.
- R4: In free-run, a newly requested reference goes to switching. The holdover code goes to holdover only if history is valid; otherwise the block stays in free-run.
- R5: Holdover goes to free-run on the free-run code or when history becomes invalid. It goes to switching when the chosen reference is qualified again or a different reference is requested.
- R6: Locking goes to holdover, with `ref_in_use`=0, on the holdover code or, in manual mode (`auto_en`=0), when the reference in use stops being both present and qualified.
- R7: In switching, a qualified target goes to locking on the next edge. An unqualified target goes to holdover in manual mode. In auto mode the block locks to `best_ref` if that reference is qualified, and otherwise goes to holdover. In locking with auto mode, loss of the reference switches to `best_ref` when it is qualified.
- R8: `status_byte` = {history valid, 3-bit reference in use, 4-bit `pll_status`}. The reference field is 0 except in locking.
- R9: With `revert_en`=1, while locked to a fallback reference, a return of the chosen reference to the qualified state re-enters switching and then locks to it. With `revert_en`=0 the block stays on the fallback.
- R10: `pll_status` in locking is 1 for frequency acquisition, 2 for phase acquisition, and 3, 4, 5, 6 for tracking bandwidths 0 to 3. `freq_acq` moves from 1 to 2. Each `phase_acq` strobe moves one step further and saturates at 6. Holdover shows 8 and free-run shows 9.
- R11: History becomes valid after HIST_CYCLES consecutive cycles in a tracking substate. A `hist_clr` pulse makes it invalid on the next edge.
- R12: Switching entered from locking reports `pll_status`=7 (phase build-out). Switching entered from free-run or holdover reports 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_mode | input | 3 | Mode code from pins |
| reg_mode | input | 4 | Mode code from configuration register |
| use_reg | input | 1 | 1 selects the register code, 0 the pins |
| ref_present | input | NUM_REF | Per-reference presence flags |
| ref_qual | input | NUM_REF | Per-reference in-range flags |
| auto_en | input | 1 | Automatic fallback enable |
| revert_en | input | 1 | Revertive return enable |
| best_ref | input | 3 | Highest-priority available reference, 0 for none |
| freq_acq | input | 1 | Frequency acquired strobe from the loop |
| phase_acq | input | 1 | Phase acquired / tracking step strobe |
| hist_clr | input | 1 | History clear pulse |
| mode_o | output | 2 | Current top-level state |
| ref_in_use | output | 3 | Reference being locked to, 0 for none |
| pll_status | output | 4 | Loop status code |
| status_byte | output | 8 | Packed history flag, reference and status |
| holdover_ind | output | 1 | High in holdover |
| freerun_ind | output | 1 | High in free-run |
| unlock_ind | output | 1 | High in switching or before phase acquisition |

## Verification
Every decision is registered once. A change on any input appears on all outputs one clock edge later. A transition such as request, then switching, then locking takes one edge per hop. History becomes visible HIST_CYCLES edges after tracking is entered. A clear pulse shows in the status byte on the next edge, and the holdover-to-free-run move follows one edge after that. The bench changes inputs on the falling edge and reads outputs on the following falling edge. It steps one edge per hop, so every expected value is read in the exact cycle it is due.

// File: rtl/refclk_mode_pkg.sv
`timescale 1ns/1ps
package refclk_mode_pkg;
  localparam int REF_IDX_W = 3;

  typedef enum logic [1:0] {
    M_FREERUN = 2'd0,
    M_SWITCH  = 2'd1,
    M_LOCK    = 2'd2,
    M_HOLD    = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    L_FREQ  = 3'd0,
    L_PHASE = 3'd1,
    L_TRK0  = 3'd2,
    L_TRK1  = 3'd3,
    L_TRK2  = 3'd4,
    L_TRK3  = 3'd5
  } lock_sub_e;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_FREE = 2'd1,
    REQ_HOLD = 2'd2,
    REQ_REF  = 2'd3
  } req_kind_e;

  localparam logic [3:0] ST_NOLOCK = 4'd0;
  localparam logic [3:0] ST_FACQ   = 4'd1;
  localparam logic [3:0] ST_PACQ   = 4'd2;
  localparam logic [3:0] ST_TRK0   = 4'd3;
  localparam logic [3:0] ST_TRK1   = 4'd4;
  localparam logic [3:0] ST_TRK2   = 4'd5;
  localparam logic [3:0] ST_TRK3   = 4'd6;
  localparam logic [3:0] ST_BUILD  = 4'd7;
  localparam logic [3:0] ST_HOLD   = 4'd8;
  localparam logic [3:0] ST_FREE   = 4'd9;
endpackage

// File: rtl/mode_code_decode.sv
`timescale 1ns/1ps
module mode_code_decode
  import refclk_mode_pkg::*;
(
  input  logic [2:0]           pin_mode_i,
  input  logic [3:0]           reg_mode_i,
  input  logic                 use_reg_i,
  output req_kind_e            req_kind_o,
  output logic [REF_IDX_W-1:0] req_ref_o,
  output logic [3:0]           req_code_o
);
  logic [3:0] code;

  always_comb begin
    code       = use_reg_i ? reg_mode_i : {1'b0, pin_mode_i};
    req_code_o = code;
    req_kind_o = REQ_REF;
    req_ref_o  = '0;
    if (code[3]) begin
      req_kind_o = REQ_NONE;
    end else begin
      case (code[2:0])
        3'b000:  req_kind_o = REQ_FREE;
        3'b011:  req_kind_o = REQ_HOLD;
        3'b001:  req_ref_o  = REF_IDX_W'(1);
        3'b010:  req_ref_o  = REF_IDX_W'(2);
        3'b100:  req_ref_o  = REF_IDX_W'(3);
        3'b101:  req_ref_o  = REF_IDX_W'(4);
        3'b110:  req_ref_o  = REF_IDX_W'(5);
        default: req_ref_o  = REF_IDX_W'(6);
      endcase
    end
  end
endmodule

// File: rtl/hist_tracker.sv
`timescale 1ns/1ps
module hist_tracker #(
  parameter int HIST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tracking_i,
  input  logic hist_clr_i,
  output logic hist_valid_o
);
  localparam int CW = $clog2(HIST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HIST_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          vld_q, vld_d;
  logic          en;

  always_comb begin
    cnt_d = cnt_q;
    vld_d = vld_q;
    if (hist_clr_i) begin
      cnt_d = '0;
      vld_d = 1'b0;
    end else if (!tracking_i) begin
      cnt_d = '0;
    end else if (!vld_q) begin
      if (cnt_q == LAST) begin
        vld_d = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
    en = (cnt_d != cnt_q) || (vld_d != vld_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign hist_valid_o = vld_q;
endmodule

// File: rtl/mode_fsm.sv
`timescale 1ns/1ps
module mode_fsm
  import refclk_mode_pkg::*;
#(
  parameter int NUM_REF = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  req_kind_e            req_kind_i,
  input  logic [REF_IDX_W-1:0] req_ref_i,
  input  logic [3:0]           req_code_i,
  input  logic [NUM_REF-1:0]   ref_present_i,
  input  logic [NUM_REF-1:0]   ref_qual_i,
  input  logic                 hist_valid_i,
  input  logic                 auto_en_i,
  input  logic                 revert_en_i,
  input  logic [REF_IDX_W-1:0] best_ref_i,
  input  logic                 freq_acq_i,
  input  logic                 phase_acq_i,
  output mode_e                mode_o,
  output lock_sub_e            sub_o,
  output logic [REF_IDX_W-1:0] ref_o,
  output logic                 buildout_o
);
  localparam int SLOTS = 1 << REF_IDX_W;

  mode_e                mode_q, mode_d;
  lock_sub_e            sub_q, sub_d;
  logic [REF_IDX_W-1:0] ref_q, ref_d, tgt_q, tgt_d, home_q, home_d;
  logic [3:0]           prev_q, prev_d;
  logic                 bo_q, bo_d;
  logic [SLOTS-1:0]     ok_vec;
  logic                 chg;

  // slot 0 means "no reference" and is never usable
  always_comb begin
    ok_vec = '0;
    for (int i = 0; i < NUM_REF; i++) begin
      ok_vec[i+1] = ref_present_i[i] & ref_qual_i[i];
    end
  end

  always_comb begin
    mode_d = mode_q;
    sub_d  = sub_q;
    ref_d  = ref_q;
    tgt_d  = tgt_q;
    home_d = home_q;
    prev_d = prev_q;
    bo_d   = bo_q;
    chg    = (req_kind_i != REQ_NONE) && (req_code_i != prev_q);

    if (chg) begin
      prev_d = req_code_i;
      home_d = (req_kind_i == REQ_REF) ? req_ref_i : '0;
    end

    case (mode_q)
      M_FREERUN: begin
        if (chg && req_kind_i == REQ_HOLD && hist_valid_i) begin
          mode_d = M_HOLD;
        end else if (chg && req_kind_i == REQ_REF) begin
          mode_d = M_SWITCH;
          tgt_d  = req_ref_i;
          bo_d   = 1'b0;
        end
      end
      M_SWITCH: begin
        if (chg && req_kind_i == REQ_FREE) begin
          mode_d = M_FREERUN;
        end else if (chg && req_kind_i == REQ_HOLD) begin
          mode_d = M_HOLD;
        end else if (chg && req_kind_i == REQ_REF) begin
          tgt_d = req_ref_i;
          bo_d  = 1'b0;
        end else if (ok_vec[tgt_q]) begin
          mode_d = M_LOCK;
          ref_d  = tgt_q;
          sub_d  = L_FREQ;
        end else if (auto_en_i && ok_vec[best_ref_i]) begin
          mode_d = M_LOCK;
          ref_d  = best_ref_i;
          sub_d  = L_FREQ;
        end else begin
          mode_d = M_HOLD;
        end
      end
      M_LOCK: begin
        if (chg && req_kind_i == REQ_FREE) begin
          mode_d = M_FREERUN;
          ref_d  = '0;
        end else if (chg && req_kind_i == REQ_HOLD) begin
          mode_d = M_HOLD;
          ref_d  = '0;
        end else if (chg && req_ref_i != ref_q) begin
          mode_d = M_SWITCH;
          tgt_d  = req_ref_i;
          ref_d  = '0;
          bo_d   = 1'b1;
        end else if (!ok_vec[ref_q]) begin
          ref_d = '0;
          if (auto_en_i && ok_vec[best_ref_i]) begin
            mode_d = M_SWITCH;
            tgt_d  = best_ref_i;
            bo_d   = 1'b1;
          end else begin
            mode_d = M_HOLD;
          end
        end else if (revert_en_i && home_q != '0 && home_q != ref_q && ok_vec[home_q]) begin
          mode_d = M_SWITCH;
          tgt_d  = home_q;
          ref_d  = '0;
          bo_d   = 1'b1;
        end else begin
          case (sub_q)
            L_FREQ:  if (freq_acq_i)  sub_d = L_PHASE;
            L_PHASE: if (phase_acq_i) sub_d = L_TRK0;
            L_TRK0:  if (phase_acq_i) sub_d = L_TRK1;
            L_TRK1:  if (phase_acq_i) sub_d = L_TRK2;
            L_TRK2:  if (phase_acq_i) sub_d = L_TRK3;
            L_TRK3:  sub_d = L_TRK3;
            default: sub_d = L_FREQ;
          endcase
        end
      end
      default: begin // M_HOLD
        if (chg && req_kind_i == REQ_FREE) begin
          mode_d = M_FREERUN;
        end else if (chg && req_kind_i == REQ_REF) begin
          mode_d = M_SWITCH;
          tgt_d  = req_ref_i;
          bo_d   = 1'b0;
        end else if (!hist_valid_i) begin
          mode_d = M_FREERUN;
        end else if (home_q != '0 && ok_vec[home_q]) begin
          mode_d = M_SWITCH;
          tgt_d  = home_q;
          bo_d   = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_FREERUN;
      sub_q  <= L_FREQ;
      ref_q  <= '0;
      tgt_q  <= '0;
      home_q <= '0;
      prev_q <= '0;
      bo_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sub_q  <= sub_d;
      ref_q  <= ref_d;
      tgt_q  <= tgt_d;
      home_q <= home_d;
      prev_q <= prev_d;
      bo_q   <= bo_d;
    end
  end

  assign mode_o     = mode_q;
  assign sub_o      = sub_q;
  assign ref_o      = ref_q;
  assign buildout_o = bo_q;
endmodule

// File: rtl/status_pack.sv
`timescale 1ns/1ps
module status_pack
  import refclk_mode_pkg::*;
(
  input  mode_e                mode_i,
  input  lock_sub_e            sub_i,
  input  logic [REF_IDX_W-1:0] ref_i,
  input  logic                 buildout_i,
  input  logic                 hist_valid_i,
  output logic [3:0]           pll_status_o,
  output logic [7:0]           status_byte_o,
  output logic                 holdover_ind_o,
  output logic                 freerun_ind_o,
  output logic                 unlock_ind_o
);
  always_comb begin
    case (mode_i)
      M_FREERUN: pll_status_o = ST_FREE;
      M_HOLD:    pll_status_o = ST_HOLD;
      M_SWITCH:  pll_status_o = buildout_i ? ST_BUILD : ST_NOLOCK;
      default: begin
        case (sub_i)
          L_FREQ:  pll_status_o = ST_FACQ;
          L_PHASE: pll_status_o = ST_PACQ;
          L_TRK0:  pll_status_o = ST_TRK0;
          L_TRK1:  pll_status_o = ST_TRK1;
          L_TRK2:  pll_status_o = ST_TRK2;
          default: pll_status_o = ST_TRK3;
        endcase
      end
    endcase
    status_byte_o  = {hist_valid_i, ref_i, pll_status_o};
    holdover_ind_o = (mode_i == M_HOLD);
    freerun_ind_o  = (mode_i == M_FREERUN);
    unlock_ind_o   = (mode_i == M_SWITCH) ||
                     (mode_i == M_LOCK && (sub_i == L_FREQ || sub_i == L_PHASE));
  end
endmodule

// File: rtl/refclk_mode_ctrl.sv
`timescale 1ns/1ps
module refclk_mode_ctrl
  import refclk_mode_pkg::*;
#(
  parameter int NUM_REF     = 6,
  parameter int HIST_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         pin_mode,
  input  logic [3:0]         reg_mode,
  input  logic               use_reg,
  input  logic [NUM_REF-1:0] ref_present,
  input  logic [NUM_REF-1:0] ref_qual,
  input  logic               auto_en,
  input  logic               revert_en,
  input  logic [2:0]         best_ref,
  input  logic               freq_acq,
  input  logic               phase_acq,
  input  logic               hist_clr,
  output logic [1:0]         mode_o,
  output logic [2:0]         ref_in_use,
  output logic [3:0]         pll_status,
  output logic [7:0]         status_byte,
  output logic               holdover_ind,
  output logic               freerun_ind,
  output logic               unlock_ind
);
  req_kind_e            req_kind;
  logic [REF_IDX_W-1:0] req_ref;
  logic [3:0]           req_code;
  mode_e                mode;
  lock_sub_e            sub;
  logic [REF_IDX_W-1:0] cur_ref;
  logic                 buildout;
  logic                 hist_valid;
  logic                 tracking;

  mode_code_decode u_dec (
    .pin_mode_i (pin_mode),
    .reg_mode_i (reg_mode),
    .use_reg_i  (use_reg),
    .req_kind_o (req_kind),
    .req_ref_o  (req_ref),
    .req_code_o (req_code)
  );

  assign tracking = (mode == M_LOCK) && (sub != L_FREQ) && (sub != L_PHASE);

  hist_tracker #(.HIST_CYCLES(HIST_CYCLES)) u_hist (
    .clk          (clk),
    .rst_n        (rst_n),
    .tracking_i   (tracking),
    .hist_clr_i   (hist_clr),
    .hist_valid_o (hist_valid)
  );

  mode_fsm #(.NUM_REF(NUM_REF)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_kind_i    (req_kind),
    .req_ref_i     (req_ref),
    .req_code_i    (req_code),
    .ref_present_i (ref_present),
    .ref_qual_i    (ref_qual),
    .hist_valid_i  (hist_valid),
    .auto_en_i     (auto_en),
    .revert_en_i   (revert_en),
    .best_ref_i    (best_ref),
    .freq_acq_i    (freq_acq),
    .phase_acq_i   (phase_acq),
    .mode_o        (mode),
    .sub_o         (sub),
    .ref_o         (cur_ref),
    .buildout_o    (buildout)
  );

  status_pack u_stat (
    .mode_i         (mode),
    .sub_i          (sub),
    .ref_i          (cur_ref),
    .buildout_i     (buildout),
    .hist_valid_i   (hist_valid),
    .pll_status_o   (pll_status),
    .status_byte_o  (status_byte),
    .holdover_ind_o (holdover_ind),
    .freerun_ind_o  (freerun_ind),
    .unlock_ind_o   (unlock_ind)
  );

  assign mode_o     = mode;
  assign ref_in_use = cur_ref;
endmodule

// File: rtl/refclk_mode_ctrl_chk.sv
`timescale 1ns/1ps
module refclk_mode_ctrl_chk #(
  parameter int NUM_REF = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_REF-1:0] ref_present,
  input logic [NUM_REF-1:0] ref_qual,
  input logic [3:0]         pll_status,
  input logic [7:0]         status_byte,
  input logic               holdover_ind,
  input logic               freerun_ind,
  input logic               unlock_ind
);
  logic cur_ok;
  logic locked;

  always_comb begin
    cur_ok = 1'b0;
    for (int i = 0; i < NUM_REF; i++) begin
      if (status_byte[6:4] == 3'(i + 1)) cur_ok = ref_present[i] & ref_qual[i];
    end
    locked = (pll_status >= 4'd1) && (pll_status <= 4'd6);
  end

  assert_ind_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({holdover_ind, freerun_ind, unlock_ind}));

  assert_fr_hold_needs_hist_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover_ind && $past(freerun_ind)) |-> $past(status_byte[7]));

  assert_lost_ref_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !cur_ok) |=> (status_byte[6:4] == 3'd0));

  assert_idle_no_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_status == 4'd8 || pll_status == 4'd9) |-> (status_byte[6:4] == 3'd0));

  assert_track_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_status >= 4'd4 && pll_status <= 4'd6) |->
      ($past(pll_status) == pll_status || $past(pll_status) == pll_status - 4'd1));

  assert_hist_from_tracking_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_byte[7]) |-> ($past(pll_status) >= 4'd3 && $past(pll_status) <= 4'd6));
endmodule

bind refclk_mode_ctrl refclk_mode_ctrl_chk #(.NUM_REF(NUM_REF)) u_chk (.*);

// File: tb/refclk_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module refclk_mode_ctrl_tb_top;
  localparam int NUM_REF = 6;
  localparam int HIST    = 16;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [2:0]         pin_mode;
  logic [3:0]         reg_mode;
  logic               use_reg;
  logic [NUM_REF-1:0] ref_present, ref_qual;
  logic               auto_en, revert_en;
  logic [2:0]         best_ref;
  logic               freq_acq, phase_acq, hist_clr;
  logic [1:0]         mode_o;
  logic [2:0]         ref_in_use;
  logic [3:0]         pll_status;
  logic [7:0]         status_byte;
  logic               holdover_ind, freerun_ind, unlock_ind;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  refclk_mode_ctrl #(.NUM_REF(NUM_REF), .HIST_CYCLES(HIST)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .reg_mode(reg_mode),
    .use_reg(use_reg), .ref_present(ref_present), .ref_qual(ref_qual),
    .auto_en(auto_en), .revert_en(revert_en), .best_ref(best_ref),
    .freq_acq(freq_acq), .phase_acq(phase_acq), .hist_clr(hist_clr),
    .mode_o(mode_o), .ref_in_use(ref_in_use), .pll_status(pll_status),
    .status_byte(status_byte), .holdover_ind(holdover_ind),
    .freerun_ind(freerun_ind), .unlock_ind(unlock_ind)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk_st(input string tag, input logic [1:0] m, input logic [3:0] s, input logic [7:0] b);
    chk({tag, " mode"}, 32'(mode_o), 32'(m));
    chk({tag, " status"}, 32'(pll_status), 32'(s));
    chk({tag, " byte"}, 32'(status_byte), 32'(b));
  endtask

  task automatic pulse_fa();
    freq_acq = 1'b1; step(1); freq_acq = 1'b0;
  endtask

  task automatic pulse_pa();
    phase_acq = 1'b1; step(1); phase_acq = 1'b0;
  endtask

  task automatic t_reset();
    chk_st("R1 reset", 2'd0, 4'd9, 8'h09);
    chk("R1 freerun_ind", 32'(freerun_ind), 1);
    chk("R1 other ind", 32'({holdover_ind, unlock_ind}), 0);
  endtask

  task automatic t_pin_lock();
    pin_mode = 3'b001; step(1);
    chk_st("R2 ref1 switching", 2'd1, 4'd0, 8'h10 & 8'h00);
    chk("R2 unlock_ind", 32'(unlock_ind), 1);
    step(1);
    chk_st("R7 lock ref1", 2'd2, 4'd1, 8'h11);
    pulse_fa(); chk("R10 phase acq", 32'(pll_status), 2);
    pulse_pa(); chk("R10 track bw0", 32'(pll_status), 3);
    chk("R10 unlock off", 32'(unlock_ind), 0);
    pulse_pa(); chk("R10 track bw1", 32'(pll_status), 4);
    pulse_pa(); chk("R10 track bw2", 32'(pll_status), 5);
    pulse_pa(); chk("R10 track bw3", 32'(pll_status), 6);
    pulse_pa(); chk("R10 saturate", 32'(pll_status), 6);
    chk("R11 history not yet", 32'(status_byte[7]), 0);
    step(HIST);
    chk_st("R11 history valid", 2'd2, 4'd6, 8'h96);
  endtask

  task automatic t_loss_manual();
    ref_qual[0] = 1'b0; step(1);
    chk_st("R6 loss to holdover", 2'd3, 4'd8, 8'h88);
    chk("R6 holdover_ind", 32'(holdover_ind), 1);
  endtask

  task automatic t_reacquire();
    ref_qual[0] = 1'b1; step(1);
    chk_st("R5 reacquire switching", 2'd1, 4'd0, 8'h80);
    step(1);
    chk_st("R5 relock ref1", 2'd2, 4'd1, 8'h91);
  endtask

  task automatic t_auto_fallback();
    auto_en = 1'b1; best_ref = 3'd3;
    ref_qual[0] = 1'b0; step(1);
    chk_st("R12 build-out switching", 2'd1, 4'd7, 8'h87);
    step(1);
    chk_st("R7 auto lock ref3", 2'd2, 4'd1, 8'hB1);
  endtask

  task automatic t_revert();
    ref_qual[0] = 1'b1; step(2);
    chk_st("R9 no revert when disabled", 2'd2, 4'd1, 8'hB1);
    revert_en = 1'b1; step(1);
    chk_st("R9 revert switching", 2'd1, 4'd7, 8'h87);
    step(1);
    chk_st("R9 revert lock ref1", 2'd2, 4'd1, 8'h91);
    revert_en = 1'b0; auto_en = 1'b0; best_ref = 3'd0;
  endtask

  task automatic t_hold_code();
    pin_mode = 3'b011; step(1);
    chk_st("R6 holdover code", 2'd3, 4'd8, 8'h88);
    pin_mode = 3'b100; step(1);
    chk_st("R5 new ref from holdover", 2'd1, 4'd0, 8'h80);
    step(1);
    chk_st("R2 lock ref3 code 100", 2'd2, 4'd1, 8'hB1);
    pin_mode = 3'b011; step(1);
    chk("R6 holdover again", 32'(mode_o), 3);
    pin_mode = 3'b000; step(1);
    chk_st("R5 freerun code", 2'd0, 4'd9, 8'h89);
  endtask

  task automatic t_fr_hold();
    pin_mode = 3'b011; step(1);
    chk_st("R4 freerun to holdover", 2'd3, 4'd8, 8'h88);
    hist_clr = 1'b1; step(1); hist_clr = 1'b0;
    chk("R11 history cleared", 32'(status_byte[7]), 0);
    step(1);
    chk_st("R5 history lost", 2'd0, 4'd9, 8'h09);
    pin_mode = 3'b000; step(1);
    pin_mode = 3'b011; step(1);
    chk_st("R4 no history stays freerun", 2'd0, 4'd9, 8'h09);
    step(1);
    chk("R4 still freerun", 32'(mode_o), 0);
    pin_mode = 3'b000; step(1);
  endtask

  task automatic t_manual_unqual();
    ref_qual[1] = 1'b0;
    pin_mode = 3'b010; step(1);
    chk("R7 manual switching", 32'(mode_o), 1);
    step(1);
    chk_st("R7 manual unqualified holdover", 2'd3, 4'd8, 8'h08);
    step(1);
    chk("R5 no history to freerun", 32'(mode_o), 0);
    pin_mode = 3'b000; step(1);
  endtask

  task automatic t_auto_none();
    auto_en = 1'b1; best_ref = 3'd0;
    pin_mode = 3'b010; step(2);
    chk_st("R7 auto none holdover", 2'd3, 4'd8, 8'h08);
    pin_mode = 3'b000; step(1);
    chk("R5 freerun code from holdover", 32'(mode_o), 0);
    auto_en = 1'b0; ref_qual[1] = 1'b1;
  endtask

  task automatic t_reg();
    reg_mode = 4'b0110; use_reg = 1'b1; step(2);
    chk_st("R3 register ref5", 2'd2, 4'd1, 8'h51);
    pin_mode = 3'b001; step(1);
    chk_st("R3 pins ignored", 2'd2, 4'd1, 8'h51);
    reg_mode = 4'b1010; step(1);
    chk_st("R3 invalid register code", 2'd2, 4'd1, 8'h51);
    reg_mode = 4'b0111; step(2);
    chk_st("R3 register ref6", 2'd2, 4'd1, 8'h61);
    reg_mode = 4'b0000; step(1);
    chk_st("R3 register freerun", 2'd0, 4'd9, 8'h09);
    pin_mode = 3'b000; use_reg = 1'b0; step(1);
    chk("R3 back to pins", 32'(mode_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; pin_mode = 3'b000; reg_mode = 4'b0000; use_reg = 1'b0;
    ref_present = '1; ref_qual = '1; auto_en = 1'b0; revert_en = 1'b0;
    best_ref = 3'd0; freq_acq = 1'b0; phase_acq = 1'b0; hist_clr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_pin_lock();
    t_loss_manual();
    t_reacquire();
    t_auto_fallback();
    t_revert();
    t_hold_code();
    t_fr_hold();
    t_manual_unqual();
    t_auto_none();
    t_reg();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule